// File: doc/BRIEF.md
# Multi-Channel Waveform Generator

This block produces sample codes for several independent signal channels. Each channel keeps a phase accumulator that moves forward by a programmable step on every accepted sample. A programmable phase shift is added to the accumulator, and the result selects a point on one of several shapes: sine, cosine, square, an eight-harmonic multitone, or a full-scale logic square. Except in logic mode, the shape is then scaled so that its swing runs from a programmed low code to a programmed high code. A one-bit converter further down the chain turns each code into a pin signal.

All channels share a single sample stream with valid/ready handshaking. `out_valid` rises in the first cycle after reset and stays high. A sample is transferred in every cycle where `out_ready` is high. While `out_ready` is low the consumer applies back-pressure: every accumulator is frozen, and the codes and sync bit on the stream do not change. The exception is a settings write, which can change the codes during a stall. A sync bit travels with the samples. It marks the first sample after the reference channel (channel 0) wraps through phase zero, and it gives the phase reference for all the channels. The settings are loaded through a plain write strobe that carries a channel number, a field code and a data word.

Top module: `wavegen_top`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0. From the first rising edge with `rst_n` high, `out_valid` is 1 and stays 1. Reset clears every accumulator, step and phase shift, sets low to 0, sets high to 4095 and selects the sine shape.
- R2: On a clock edge with `cfg_we` high, the field given by `cfg_field` of channel `cfg_ch` is loaded. The field codes are: 0 step (32 bits), 1 phase shift (32 bits), 2 low code (bits 11:0), 3 high code (bits 11:0), 4 shape (bits 2:0). The new value affects the sample shown after that edge. Field codes 5 to 7 change nothing.
- R3: On every transfer (`out_valid` and `out_ready` both high), each accumulator adds its step modulo 2^32. The phase p is the accumulator plus the phase shift, modulo 2^32.
- R4: While `out_ready` is low, the accumulators, `out_codes` and `out_sync` hold their values, unless a settings write takes place.
- R5: Shape 0 (sine), and shape codes 5 to 7, use i = p[31:22] and s = sin(2π(i+0.5)/1024). The wave is 2048+round(2047.5·s) when s > 0, and otherwise 2047−round(2047.5·|s|).
- R6: Shape 1 (cosine) is the sine of p+2^30. Shape 2 (square) is wave 4095 while p[31] is 0, and 0 otherwise.
- R7: Shape 3 (multitone) is the floor of the mean of the sine waves of (h·p mod 2^32) for h = 1 to 8.
- R8: With low ≤ high, code = low + floor((high−low)·w′/4096), where w′ = wave + 1 if wave ≥ 2048, and w′ = wave otherwise. A wave of 0 gives low and a wave of 4095 gives high.
- R9: With low > high, the channel outputs the low code constantly, for every shape except logic.
- R10: Shape 4 (logic) outputs 4095 while p[31] is 0 and 0 otherwise, whatever the low and high codes are.
- R11: `out_sync` is 1 on exactly those samples that follow a transfer in which channel 0's accumulator carried out of bit 31. It is 0 after reset.
- R12: Channel c drives `out_codes[12c+11:12c]`. A write to one channel leaves every other channel unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Settings write strobe |
| cfg_ch | input | 3 | Channel to write |
| cfg_field | input | 3 | Field code to write |
| cfg_wdata | input | 32 | Write data |
| out_valid | output | 1 | Sample stream valid |
| out_ready | input | 1 | Sample stream ready from the consumer |
| out_codes | output | 96 | Eight 12-bit codes, one per channel |
| out_sync | output | 1 | Phase-zero marker of the sample |

## Verification
On every cycle the assertions check these properties: a logic-mode output is only ever 0 or 4095; a scaled code stays within the window from low to high, and is pinned to low when the levels are crossed; a stall freezes the accumulators, the codes and the sync bit; valid stays high once raised; and sync rises only after a transfer. Some behaviours need exact values, and only the bench's reference model, compared on every cycle, can show them: the exact sine, cosine and multitone values, accumulator wrap points, the timing of writes, and the ignoring of unused field codes.

// File: rtl/wg_pkg.sv
package wg_pkg;
  // Settings field codes
  localparam logic [2:0] FLD_STEP  = 3'd0;
  localparam logic [2:0] FLD_SHIFT = 3'd1;
  localparam logic [2:0] FLD_LOW   = 3'd2;
  localparam logic [2:0] FLD_HIGH  = 3'd3;
  localparam logic [2:0] FLD_SHAPE = 3'd4;
  // Shape codes
  localparam logic [2:0] SHP_SINE  = 3'd0;
  localparam logic [2:0] SHP_COS   = 3'd1;
  localparam logic [2:0] SHP_SQR   = 3'd2;
  localparam logic [2:0] SHP_MULTI = 3'd3;
  localparam logic [2:0] SHP_LOGIC = 3'd4;
  localparam real        PI_VAL    = 3.141592653589793;
endpackage

// File: rtl/wg_sine_table.sv
module wg_sine_table #(
  parameter int CODE_W = 12,
  parameter int IDX_W  = 10
) (
  output logic [(2**(IDX_W-2))*(CODE_W-1)-1:0] qtab
);
  localparam int  QW   = CODE_W - 1;
  localparam int  QDEP = 2**(IDX_W-2);
  localparam real AMP  = ((2.0**CODE_W) - 1.0) / 2.0;

  // Quarter-wave magnitudes, sampled at half-step centres
  for (genvar k = 0; k < QDEP; k++) begin : g_q
    localparam real ANG = 2.0 * wg_pkg::PI_VAL * (real'(k) + 0.5) / real'(4 * QDEP);
    localparam int  QV  = $rtoi(AMP * $sin(ANG) + 0.5);
    assign qtab[k*QW +: QW] = QW'(QV);
  end
endmodule

// File: rtl/wg_shaper.sv
module wg_shaper #(
  parameter int ACC_W  = 32,
  parameter int CODE_W = 12,
  parameter int IDX_W  = 10,
  parameter int HARM   = 8
) (
  input  logic [ACC_W-1:0]                        phase,
  input  logic [2:0]                              shape,
  input  logic [(2**(IDX_W-2))*(CODE_W-1)-1:0]    qtab,
  output logic [CODE_W-1:0]                       wave
);
  import wg_pkg::*;
  localparam int QW    = CODE_W - 1;
  localparam int QA    = IDX_W - 2;
  localparam int HSH   = $clog2(HARM);
  localparam int SUM_W = CODE_W + HSH;
  localparam logic [CODE_W-1:0] MID_HI  = CODE_W'(2**(CODE_W-1));
  localparam logic [CODE_W-1:0] MID_LO  = MID_HI - 1'b1;
  localparam logic [ACC_W-1:0]  QUARTER = ACC_W'(1) << (ACC_W-2);

  function automatic logic [CODE_W-1:0] lut(input logic [IDX_W-1:0] idx);
    logic [QA-1:0] a;
    logic [QW-1:0] q;
    a = idx[QA-1:0];
    if (idx[QA]) a = ~a;               // mirror in falling quarters
    q = qtab[int'(a)*QW +: QW];
    if (idx[IDX_W-1]) lut = MID_LO - {1'b0, q};
    else              lut = MID_HI + {1'b0, q};
  endfunction

  logic [ACC_W-1:0] cos_ph;
  logic [ACC_W-1:0] harm_ph;
  logic [SUM_W-1:0] harm_sum;

  always_comb begin
    cos_ph   = phase + QUARTER;
    harm_sum = '0;
    harm_ph  = '0;
    for (int h = 1; h <= HARM; h++) begin
      harm_ph  = phase * ACC_W'(h);
      harm_sum = harm_sum + SUM_W'(lut(harm_ph[ACC_W-1 -: IDX_W]));
    end
    case (shape)
      SHP_COS:            wave = lut(cos_ph[ACC_W-1 -: IDX_W]);
      SHP_SQR, SHP_LOGIC: wave = phase[ACC_W-1] ? '0 : '1;
      SHP_MULTI:          wave = harm_sum[SUM_W-1 -: CODE_W];
      default:            wave = lut(phase[ACC_W-1 -: IDX_W]);
    endcase
  end
endmodule

// File: rtl/wg_scaler.sv
module wg_scaler #(
  parameter int CODE_W = 12
) (
  input  logic [CODE_W-1:0] wave,
  input  logic [CODE_W-1:0] lo,
  input  logic [CODE_W-1:0] hi,
  input  logic              is_logic,
  output logic [CODE_W-1:0] code
);
  localparam int PW = 2*CODE_W + 1;

  logic [CODE_W:0]   wext;
  logic [CODE_W-1:0] span;
  logic [PW-1:0]     prod;

  always_comb begin
    // stretch top half by one step so full wave reaches exactly 2^CODE_W
    wext = {1'b0, wave} + {{CODE_W{1'b0}}, wave[CODE_W-1]};
    span = hi - lo;
    prod = PW'(span) * PW'(wext);
    if (is_logic)     code = wave;
    else if (lo > hi) code = lo;
    else              code = lo + prod[CODE_W +: CODE_W];
  end
endmodule

// File: rtl/wg_channel.sv
module wg_channel #(
  parameter int ACC_W  = 32,
  parameter int CODE_W = 12,
  parameter int IDX_W  = 10,
  parameter int HARM   = 8,
  parameter bit IS_REF = 1'b0
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 wr_en,
  input  logic [2:0]                           wr_field,
  input  logic [ACC_W-1:0]                     wr_data,
  input  logic                                 adv,
  input  logic [(2**(IDX_W-2))*(CODE_W-1)-1:0] qtab,
  output logic [CODE_W-1:0]                    code,
  output logic                                 wrap
);
  import wg_pkg::*;

  logic [ACC_W-1:0]  acc, step, shift, acc_nx;
  logic [CODE_W-1:0] lo, hi, wave;
  logic [2:0]        shape;
  logic              carry;

  assign {carry, acc_nx} = {1'b0, acc} + {1'b0, step};
  assign wrap = IS_REF ? carry : 1'b0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc   <= '0;
      step  <= '0;
      shift <= '0;
      lo    <= '0;
      hi    <= '1;
      shape <= SHP_SINE;
    end else begin
      if (adv) acc <= acc_nx;
      if (wr_en) begin
        case (wr_field)
          FLD_STEP:  step  <= wr_data;
          FLD_SHIFT: shift <= wr_data;
          FLD_LOW:   lo    <= wr_data[CODE_W-1:0];
          FLD_HIGH:  hi    <= wr_data[CODE_W-1:0];
          FLD_SHAPE: shape <= wr_data[2:0];
          default:   ;
        endcase
      end
    end
  end

  logic [ACC_W-1:0] phase;
  assign phase = acc + shift;

  wg_shaper #(.ACC_W(ACC_W), .CODE_W(CODE_W), .IDX_W(IDX_W), .HARM(HARM)) i_shaper (
    .phase(phase), .shape(shape), .qtab(qtab), .wave(wave)
  );

  wg_scaler #(.CODE_W(CODE_W)) i_scaler (
    .wave(wave), .lo(lo), .hi(hi), .is_logic(shape == SHP_LOGIC), .code(code)
  );

  AST_LOGIC_FULLSCALE: assert property (@(posedge clk) disable iff (!rst_n)
    (shape == SHP_LOGIC) |-> (code == '0 || code == '1));                        // R10
  AST_LEVEL_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (shape != SHP_LOGIC && lo <= hi) |-> (code >= lo && code <= hi));            // R8
  AST_CROSSED_LEVELS: assert property (@(posedge clk) disable iff (!rst_n)
    (shape != SHP_LOGIC && lo > hi) |-> (code == lo));                           // R9
  AST_ACC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(acc));                                                      // R4
endmodule

// File: rtl/wavegen_top.sv
module wavegen_top #(
  parameter int NUM_CH = 8,
  parameter int ACC_W  = 32,
  parameter int CODE_W = 12,
  parameter int IDX_W  = 10,
  parameter int HARM   = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_we,
  input  logic [$clog2(NUM_CH)-1:0]  cfg_ch,
  input  logic [2:0]                 cfg_field,
  input  logic [ACC_W-1:0]           cfg_wdata,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic [NUM_CH*CODE_W-1:0]   out_codes,
  output logic                       out_sync
);
  localparam int CH_W = $clog2(NUM_CH);
  localparam int QLEN = (2**(IDX_W-2))*(CODE_W-1);

  logic [QLEN-1:0]   qtab;
  logic [NUM_CH-1:0] wraps;
  logic              adv;

  assign adv = out_valid && out_ready;

  wg_sine_table #(.CODE_W(CODE_W), .IDX_W(IDX_W)) i_table (.qtab(qtab));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    wg_channel #(
      .ACC_W(ACC_W), .CODE_W(CODE_W), .IDX_W(IDX_W), .HARM(HARM), .IS_REF(c == 0)
    ) i_ch (
      .clk(clk), .rst_n(rst_n),
      .wr_en(cfg_we && (cfg_ch == CH_W'(c))),
      .wr_field(cfg_field), .wr_data(cfg_wdata),
      .adv(adv), .qtab(qtab),
      .code(out_codes[c*CODE_W +: CODE_W]),
      .wrap(wraps[c])
    );
  end

  // only the reference channel can raise its wrap bit
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sync  <= 1'b0;
    end else begin
      out_valid <= 1'b1;
      if (adv) out_sync <= |wraps;
    end
  end

  AST_VALID_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> out_valid);                                                    // R1
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !cfg_we) |=> ($stable(out_codes) && $stable(out_sync))); // R4
  AST_SYNC_NEEDS_TRANSFER: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_sync) |-> $past(out_valid && out_ready));                          // R11
endmodule

// File: tb/test_wavegen_top.sv
module test_wavegen_top;
  localparam int NCH = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_ch = '0;
  logic [2:0]  cfg_field = '0;
  logic [31:0] cfg_wdata = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [95:0] out_codes;
  logic        out_sync;

  always #4 clk = ~clk;  // 125 MHz

  wavegen_top i_wavegen_top (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch),
    .cfg_field(cfg_field), .cfg_wdata(cfg_wdata), .out_valid(out_valid),
    .out_ready(out_ready), .out_codes(out_codes), .out_sync(out_sync)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // ---------------- reference model ----------------
  logic [31:0] m_acc [NCH];
  logic [31:0] m_step[NCH];
  logic [31:0] m_ofs [NCH];
  int          m_lo  [NCH];
  int          m_hi  [NCH];
  int          m_shp [NCH];
  bit          m_valid, m_sync, m_live = 1'b0;

  function automatic int sin_u(input logic [9:0] idx);
    real s;
    s = $sin(2.0 * 3.141592653589793 * (real'(idx) + 0.5) / 1024.0);
    if (s > 0.0) return 2048 + $rtoi(2047.5 * s + 0.5);
    return 2047 - $rtoi(-2047.5 * s + 0.5);
  endfunction

  function automatic int exp_code(input int c);
    logic [31:0] p, hp;
    int w, sum;
    p = m_acc[c] + m_ofs[c];
    case (m_shp[c])
      1: begin hp = p + 32'h4000_0000; w = sin_u(hp[31:22]); end
      2, 4: w = p[31] ? 0 : 4095;
      3: begin
        sum = 0;
        for (int h = 1; h <= 8; h++) begin hp = p * 32'(h); sum += sin_u(hp[31:22]); end
        w = sum / 8;
      end
      default: w = sin_u(p[31:22]);
    endcase
    if (m_shp[c] == 4) return w;
    if (m_lo[c] > m_hi[c]) return m_lo[c];
    if (w >= 2048) w = w + 1;
    return m_lo[c] + ((m_hi[c] - m_lo[c]) * w) / 4096;
  endfunction

  function automatic string tag(input int c);
    if (m_shp[c] == 4) return "R10";
    if (m_lo[c] > m_hi[c]) return "R9";
    if (m_shp[c] == 3) return "R7";
    if (m_shp[c] == 1 || m_shp[c] == 2) return "R6";
    if (m_lo[c] != 0 || m_hi[c] != 4095) return "R8";
    return "R5";
  endfunction

  always @(posedge clk) begin
    logic [32:0] sum;
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        m_acc[c] = '0; m_step[c] = '0; m_ofs[c] = '0;
        m_lo[c] = 0; m_hi[c] = 4095; m_shp[c] = 0;
      end
      m_valid = 1'b0; m_sync = 1'b0; m_live = 1'b1;
    end else if (m_live) begin
      if (m_valid && out_ready) begin        // R3: advance on transfer only
        for (int c = 0; c < NCH; c++) begin
          sum = {1'b0, m_acc[c]} + {1'b0, m_step[c]};
          if (c == 0) m_sync = sum[32];        // R11
          m_acc[c] = sum[31:0];
        end
      end
      m_valid = 1'b1;
      if (cfg_we) begin                        // R2
        case (cfg_field)
          3'd0: m_step[cfg_ch] = cfg_wdata;
          3'd1: m_ofs[cfg_ch]  = cfg_wdata;
          3'd2: m_lo[cfg_ch]   = int'(cfg_wdata[11:0]);
          3'd3: m_hi[cfg_ch]   = int'(cfg_wdata[11:0]);
          3'd4: m_shp[cfg_ch]  = int'(cfg_wdata[2:0]);
          default: ;                            // 5..7 ignored
        endcase
      end
    end
  end

  // compare on every falling edge
  always @(negedge clk) begin
    if (m_live && !done) begin
      n_chk++;
      if (out_valid !== m_valid) begin
        n_fail++;
        $display("FAIL R1 out_valid actual=%b expected=%b", out_valid, m_valid);
      end
      n_chk++;
      if (out_sync !== m_sync) begin
        n_fail++;
        $display("FAIL R11 out_sync actual=%b expected=%b", out_sync, m_sync);
      end
      for (int c = 0; c < NCH; c++) begin
        n_chk++;
        if (int'(out_codes[c*12 +: 12]) != exp_code(c) || $isunknown(out_codes[c*12 +: 12])) begin
          n_fail++;
          $display("FAIL %s ch%0d code actual=%0d expected=%0d", tag(c), c,
                   out_codes[c*12 +: 12], exp_code(c));
        end
      end
    end
  end

  task automatic wr(input int ch, input int fld, input logic [31:0] d);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_ch = 3'(ch); cfg_field = 3'(fld); cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic run(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic finish_up();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 8);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    // R1: reset state, default sine at phase zero
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    run(5);
    // R3, R11: channel 0 wraps every 64 samples
    wr(0, 0, 32'h0400_0000);
    run(150);
    // R6 cosine, square with levels (R8), R7 multitone
    wr(1, 4, 32'd1); wr(1, 0, 32'h0123_4567);
    wr(2, 4, 32'd2); wr(2, 2, 32'd100); wr(2, 3, 32'd3000); wr(2, 0, 32'h1000_0000);
    wr(3, 4, 32'd3); wr(3, 0, 32'h0080_0000);
    // R10: logic mode ignores levels
    wr(4, 4, 32'd4); wr(4, 2, 32'd500); wr(4, 3, 32'd600); wr(4, 0, 32'h0200_0000);
    // R9: crossed levels
    wr(5, 2, 32'd3000); wr(5, 3, 32'd1000); wr(5, 0, 32'h0300_0000);
    // R3: phase shift; R5 sine on full scale
    wr(6, 1, 32'h4000_0000); wr(6, 0, 32'h0070_0000);
    // R3: step that wraps backwards
    wr(7, 0, 32'hFFF0_0000);
    run(300);
    // R8: equal levels give a constant code
    wr(2, 2, 32'd1234); wr(2, 3, 32'd1234);
    // R2: field codes 5..7 change nothing; R12: other channels untouched
    wr(0, 5, 32'hFFFF_FFFF); wr(3, 7, 32'h0000_0004); wr(6, 6, 32'h1234_5678);
    run(50);
    // R4: back-pressure, irregular then long stall
    for (int i = 0; i < 120; i++) begin
      @(posedge clk); #1 out_ready = (i % 3) != 0;
    end
    @(posedge clk); #1 out_ready = 1'b0;
    run(20);
    wr(1, 4, 32'd2);                 // R2: write during stall still takes effect
    run(10);
    @(posedge clk); #1 out_ready = 1'b1;
    // R11: fastest sync rate, wrap every other sample
    wr(0, 0, 32'h8000_0000);
    run(40);
    // R10/R8 extremes: logic on low bounds, sine on tiny window
    wr(4, 2, 32'd4095); wr(4, 3, 32'd0);
    wr(6, 2, 32'd4094); wr(6, 3, 32'd4095);
    run(200);
    // R1: reset again mid-run
    @(posedge clk); #1 rst_n = 1'b0;
    run(3);
    #1 rst_n = 1'b1;
    run(20);
    @(negedge clk);
    finish_up();
  end
endmodule